// File: doc/BRIEF.md
# Double Late Write Pipelined SRAM

A synchronous single-port memory model whose data travels over a shared bus. The bus is modelled as a separate input, a registered output and an output-enable. Every command is sampled on a rising clock edge. A read returns its word one clock after the edge that captured it. A write accepts its word from the bus two edges after its command, so commands can be issued every cycle with no idle turnaround between reads and writes.

A load cycle starts an access at an external address. Further cycles with the advance input high continue that access as a burst. In a burst, the two lowest address bits step linearly and wrap inside an aligned group of four. Writes whose data has not yet arrived are tracked in a two-entry pending queue. A read that touches a queued word is served with the newest bytes, one lane at a time. The queue makes a read immediately after a write, or after two partial writes, fully coherent.

Top module: `dlw_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rvalid` and `dq_oe` are low and no burst is active.
- R2: A load cycle (`cs_n`=0, `adv`=0) with `we_n`=1 is a read. Its word appears on `dq_o` with `rvalid`=1 in the cycle that follows the next rising edge after the command edge.
- R3: A load cycle with `we_n`=0 is a write. Its data is taken from `dq_i` on the second rising edge after the command edge, which is the third edge counting the command edge.
- R4: `be_n` is sampled with each write cycle and is active low. Bit b gates bits [8b+7:8b]. Lanes whose bit is 1 keep their old contents, and `be_n`=1111 leaves the word unchanged.
- R5: A cycle with `adv`=1 while a burst is active continues the burst, whatever the value of `cs_n` or `we_n`. It repeats the operation type of the last load, and its address is the loaded address with the two lowest bits increased by the number of continue cycles so far, modulo 4. The upper bits are unchanged.
- R6: The fourth continue cycle after a load addresses the loaded word again. For example, a load at low bits 10 visits 10, 11, 00, 01 and then 10.
- R7: A read returns the word as if every earlier write had already completed. This holds even when one or two writes to the same word still wait for their data, and the later write wins in each byte lane both write.
- R8: `dq_oe` is high exactly in cycles where `rvalid` is high. It is never high in a cycle whose data is sampled by a pending write, including when reads and writes alternate every cycle.
- R9: A load cycle with `cs_n`=1 starts no operation and ends any burst. Cycles with `adv`=1 that follow it neither read nor write until the next selected load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address, used on load cycles |
| adv | input | 1 | 0 = load new address, 1 = continue burst |
| cs_n | input | 1 | Select, active low, sampled on load cycles |
| we_n | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| be_n | input | NB | Byte lane write enables, active low |
| dq_i | input | NB*8 | Data bus, incoming write data |
| dq_o | output | NB*8 | Data bus, outgoing read data |
| dq_oe | output | 1 | Bus drive enable for read data |
| rvalid | output | 1 | Read data present on `dq_o` |

## Verification
Two things can land on the same clock edge. One is a read command whose word must be fetched from the array. The other is the arrival on `dq_i` of data for an older write to that same word. Since that data is written to the array only on that edge, the read must take it straight from the bus. The bench provokes this by issuing a read one cycle and two cycles after writes to the same address, including two overlapping partial writes followed at once by a read. It judges the result against a reference model that applies each write at command time. The other collision is a read output cycle against a write data cycle during strict read/write alternation. Here the bench flags any cycle where `dq_oe` is high while it is itself driving write data.

// File: rtl/dlw_pkg.sv
`timescale 1ns/1ps
package dlw_pkg;
   // number of low address bits stepped by the burst counter
   localparam int BURST_BITS = 2;
   // width of one byte lane
   localparam int LANE_W     = 8;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/dlw_burst_ctrl.sv
`timescale 1ns/1ps
module dlw_burst_ctrl
   import dlw_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          adv,
   input  logic          cs_n,
   input  logic          we_n,
   output op_e           op,
   output logic [AW-1:0] eff_addr,
   output logic          active
);
   localparam int BB = BURST_BITS;

   logic [AW-1:0] base_q;
   logic [BB-1:0] cnt_q;
   logic          last_wr_q;
   logic          load, cont;
   logic [BB-1:0] step_lo;

   assign load    = !adv && !cs_n;
   assign cont    = adv && active;
   assign step_lo = base_q[BB-1:0] + cnt_q + BB'(1);

   generate
      if (AW == BB) begin : g_all_low
         assign eff_addr = load ? addr : step_lo;
      end else begin : g_split
         assign eff_addr = load ? addr : {base_q[AW-1:BB], step_lo};
      end
   endgenerate

   always_comb begin
      if (load)      op = we_n ? OP_RD : OP_WR;
      else if (cont) op = last_wr_q ? OP_WR : OP_RD;
      else           op = OP_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q    <= '0;
         cnt_q     <= '0;
         last_wr_q <= 1'b0;
         active    <= 1'b0;
      end else if (load) begin
         base_q    <= addr;
         cnt_q     <= '0;
         last_wr_q <= !we_n;
         active    <= 1'b1;
      end else if (!adv) begin
         active    <= 1'b0;
      end else if (active) begin
         cnt_q     <= cnt_q + BB'(1);
      end
   end
endmodule

// File: rtl/dlw_mem_array.sv
`timescale 1ns/1ps
module dlw_mem_array
   import dlw_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [AW-1:0]        waddr,
   input  logic [NB-1:0]        wen_n,
   input  logic [NB*LANE_W-1:0] wdata,
   input  logic [AW-1:0]        raddr,
   output logic [NB*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_lane
         logic [LANE_W-1:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we && !wen_n[b])
               lane_mem[waddr] <= wdata[b*LANE_W +: LANE_W];
         end

         assign rdata[b*LANE_W +: LANE_W] = lane_mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/dlw_wr_queue.sv
`timescale 1ns/1ps
module dlw_wr_queue
   import dlw_pkg::*;
#(
   parameter int AW     = 6,
   parameter int NB     = 4,
   parameter int NPROBE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic [AW-1:0]        push_addr,
   input  logic [NB-1:0]        push_be_n,
   input  logic [NB*LANE_W-1:0] bus_data,
   output logic                 commit_en,
   output logic [AW-1:0]        commit_addr,
   output logic [NB-1:0]        commit_be_n,
   input  logic [AW-1:0]        probe_addr [NPROBE],
   input  logic [NB*LANE_W-1:0] probe_d    [NPROBE],
   output logic [NB*LANE_W-1:0] probe_q    [NPROBE]
);
   // entry 1: issued last edge; entry 2: its data is on the bus now
   logic          e1_v, e2_v;
   logic [AW-1:0] e1_a, e2_a;
   logic [NB-1:0] e1_be, e2_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e1_v <= 1'b0;
         e2_v <= 1'b0;
      end else begin
         e1_v <= push;
         e2_v <= e1_v;
      end
   end

   always_ff @(posedge clk) begin
      e1_a  <= push_addr;
      e1_be <= push_be_n;
      e2_a  <= e1_a;
      e2_be <= e1_be;
   end

   assign commit_en   = e2_v;
   assign commit_addr = e2_a;
   assign commit_be_n = e2_be;

   generate
      for (genvar p = 0; p < NPROBE; p++) begin : g_probe
         logic hit;
         assign hit = e2_v && (e2_a == probe_addr[p]);
         for (genvar b = 0; b < NB; b++) begin : g_lane
            assign probe_q[p][b*LANE_W +: LANE_W] =
               (hit && !e2_be[b]) ? bus_data[b*LANE_W +: LANE_W]
                                  : probe_d[p][b*LANE_W +: LANE_W];
         end
      end
   endgenerate
endmodule

// File: rtl/dlw_sram.sv
`timescale 1ns/1ps
module dlw_sram
   import dlw_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        addr,
   input  logic                 adv,
   input  logic                 cs_n,
   input  logic                 we_n,
   input  logic [NB-1:0]        be_n,
   input  logic [NB*LANE_W-1:0] dq_i,
   output logic [NB*LANE_W-1:0] dq_o,
   output logic                 dq_oe,
   output logic                 rvalid
);
   localparam int DW = NB * LANE_W;

   generate
      if (AW < BURST_BITS) begin : g_bad_aw
         $error("dlw_sram: AW must cover the burst counter bits");
      end
      if (NB < 1) begin : g_bad_nb
         $error("dlw_sram: NB must be at least 1");
      end
   endgenerate

   op_e           op;
   logic [AW-1:0] eff_addr;
   logic          burst_act;
   logic          wq_commit;
   logic [AW-1:0] wq_addr;
   logic [NB-1:0] wq_be_n;
   logic [DW-1:0] arr_q;
   logic [AW-1:0] pr_addr [2];
   logic [DW-1:0] pr_d    [2];
   logic [DW-1:0] pr_q    [2];

   // read pipeline stage between command edge and output edge
   logic          rd1_v;
   logic [AW-1:0] rd1_addr;
   logic [DW-1:0] rd1_data;

   dlw_burst_ctrl #(.AW(AW)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .adv      (adv),
      .cs_n     (cs_n),
      .we_n     (we_n),
      .op       (op),
      .eff_addr (eff_addr),
      .active   (burst_act)
   );

   dlw_mem_array #(.AW(AW), .NB(NB)) u_mem (
      .clk   (clk),
      .we    (wq_commit),
      .waddr (wq_addr),
      .wen_n (wq_be_n),
      .wdata (dq_i),
      .raddr (eff_addr),
      .rdata (arr_q)
   );

   assign pr_addr[0] = eff_addr;
   assign pr_d[0]    = arr_q;
   assign pr_addr[1] = rd1_addr;
   assign pr_d[1]    = rd1_data;

   dlw_wr_queue #(.AW(AW), .NB(NB), .NPROBE(2)) u_wq (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (op == OP_WR),
      .push_addr   (eff_addr),
      .push_be_n   (be_n),
      .bus_data    (dq_i),
      .commit_en   (wq_commit),
      .commit_addr (wq_addr),
      .commit_be_n (wq_be_n),
      .probe_addr  (pr_addr),
      .probe_d     (pr_d),
      .probe_q     (pr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd1_v  <= 1'b0;
         rvalid <= 1'b0;
         dq_oe  <= 1'b0;
      end else begin
         rd1_v  <= (op == OP_RD);
         rvalid <= rd1_v;
         dq_oe  <= rd1_v;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd1_addr <= '0;
         rd1_data <= '0;
         dq_o     <= '0;
      end else begin
         rd1_addr <= eff_addr;
         rd1_data <= pr_q[0];
         if (rd1_v) dq_o <= pr_q[1];
      end
   end
endmodule

// File: rtl/dlw_sram_chk.sv
`timescale 1ns/1ps
module dlw_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic adv,
   input logic cs_n,
   input logic we_n,
   input logic dq_oe,
   input logic rvalid,
   input logic wq_commit,
   input logic burst_act
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!rvalid && !dq_oe && !burst_act));

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !adv && we_n) |=> ##1 rvalid);

   // R3
   wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !adv && !we_n) |=> ##1 wq_commit);

   // R8
   bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dq_oe && wq_commit));

   // R8
   write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !adv && !we_n) |=> ##1 !dq_oe);

   // R9
   no_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && $past(cs_n) && !$past(adv)) |=> ##1 (!rvalid && !wq_commit));
endmodule

bind dlw_sram dlw_sram_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adv       (adv),
   .cs_n      (cs_n),
   .we_n      (we_n),
   .dq_oe     (dq_oe),
   .rvalid    (rvalid),
   .wq_commit (wq_commit),
   .burst_act (burst_act)
);

// File: tb/sim_dlw_sram.sv
`timescale 1ns/1ps
module sim_dlw_sram;
   localparam int AW = 6, NB = 4, DW = NB * 8, DEPTH = 1 << AW;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          adv = 1'b0, cs_n = 1'b1, we_n = 1'b1;
   logic [NB-1:0] be_n = '1;
   logic [DW-1:0] dq_i = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe, rvalid;

   always #2.5 clk = ~clk;

   dlw_sram #(.AW(AW), .NB(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .cs_n(cs_n),
      .we_n(we_n), .be_n(be_n), .dq_i(dq_i), .dq_o(dq_o),
      .dq_oe(dq_oe), .rvalid(rvalid));

   int total = 0, bad = 0, seq = 0;
   bit started = 0, done = 0;
   string cur_tag = "R2";

   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] expq [$];
   string         tagq [$];

   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   bit            b_wr = 0, b_act = 0;
   logic [DW-1:0] dp1 = '0, dp2 = '0;
   bit            dv1 = 0, dv2 = 0, wd_cycle = 0;

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(int n);
      return 32'hC0DE0000 + 32'(n) * 32'h00010103;
   endfunction

   // driver: one command per clock, expected results pushed on the scoreboard
   task automatic tick(bit a_adv, bit a_cs_n, bit a_we_n,
                       logic [NB-1:0] a_be, logic [AW-1:0] a_addr,
                       logic [DW-1:0] a_data);
      logic [AW-1:0] ea = a_addr;
      bit is_rd = 0, is_wr = 0;
      if (!a_adv && !a_cs_n) begin
         b_base = a_addr; b_cnt = 0; b_wr = !a_we_n; b_act = 1;
         is_wr = b_wr; is_rd = !b_wr;
      end else if (!a_adv) begin
         b_act = 0;
      end else if (b_act) begin
         b_cnt = b_cnt + 2'd1;
         ea = {b_base[AW-1:2], 2'(b_base[1:0] + b_cnt)};
         is_wr = b_wr; is_rd = !b_wr;
      end
      if (is_wr)
         for (int b = 0; b < NB; b++)
            if (!a_be[b]) model[ea][b*8 +: 8] = a_data[b*8 +: 8];
      if (is_rd) begin
         expq.push_back(model[ea]);
         tagq.push_back(cur_tag);
      end
      adv = a_adv; cs_n = a_cs_n; we_n = a_we_n; be_n = a_be; addr = a_addr;
      dq_i = dv2 ? dp2 : (32'h5EED0000 ^ 32'(seq));
      wd_cycle = dv2;
      dp2 = dp1; dv2 = dv1;
      dp1 = a_data; dv1 = is_wr;
      seq++;
      @(posedge clk); #1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(0, 1, 1, '1, '0, '0);
   endtask
   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] be = '0);
      tick(0, 0, 0, be, a, d);
   endtask
   task automatic rd(logic [AW-1:0] a);
      tick(0, 0, 1, '1, a, '0);
   endtask
   task automatic cont(logic [DW-1:0] d, logic [NB-1:0] be = '0);
      tick(1, 0, 1, be, '0, d);
   endtask

   // monitor: samples mid-cycle and pops the scoreboard
   always @(negedge clk) begin
      if (started && rst_n) begin
         if (dq_oe && wd_cycle) begin
            total++; bad++;
            $display("FAIL R8: actual dq_oe=1 expected dq_oe=0 in write data cycle");
         end
         if (dq_oe !== rvalid) begin
            total++; bad++;
            $display("FAIL R8: actual dq_oe=%b expected dq_oe=%b", dq_oe, rvalid);
         end
         if (rvalid) begin
            if (expq.size() == 0) begin
               total++; bad++;
               $display("FAIL R9: actual rvalid=1 expected rvalid=0 (no read issued)");
            end else begin
               string t = tagq.pop_front();
               chk(t, dq_o, expq.pop_front());
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL R2: actual=hung expected=finished (watchdog)");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(4);
      // R1: reset state
      chk("R1", {31'b0, rvalid}, '0);
      chk("R1", {31'b0, dq_oe}, '0);
      rst_n = 1'b1;
      idle(1);
      chk("R1", {31'b0, rvalid}, '0);
      started = 1;

      // fill memory by aligned write bursts (R3, R5)
      cur_tag = "R5";
      for (int g = 0; g < DEPTH / 4; g++) begin
         wr(AW'(g * 4), pat(g * 4));
         for (int k = 1; k < 4; k++) cont(pat(g * 4 + k));
      end
      idle(2);

      // R2 / R3: single writes then reads
      cur_tag = "R3";
      wr(5, 32'h11223344); wr(17, 32'hA5A5_5A5A); wr(40, 32'h0BAD_F00D); wr(63, 32'hFFFF_0001);
      idle(2);
      cur_tag = "R2";
      rd(5); rd(17); rd(40); rd(63); rd(0);
      idle(3);

      // R4: byte lanes
      cur_tag = "R4";
      wr(5, 32'hAABBCCDD, 4'b1010);
      wr(17, 32'h0000_0000, 4'b1111);
      wr(40, 32'h7777_7777, 4'b0111);
      idle(2);
      rd(5); rd(17); rd(40);
      idle(3);

      // R5 / R6: burst from low bits 10, fifth access wraps to the start
      cur_tag = "R6";
      wr(10, 32'h1000_000A);
      cont(32'h1000_000B); cont(32'h1000_0008); cont(32'h1000_0009);
      cont(32'h2000_000A, 4'b1100);
      idle(2);
      tick(0, 0, 1, '1, 9, '0);
      cont('0); cont('0); cont('0); cont('0);
      idle(3);

      // R7: reads hitting one and two pending writes
      cur_tag = "R7";
      wr(20, 32'hDEAD_BEEF); rd(20); rd(20);
      wr(21, 32'h1111_1111, 4'b0001);
      wr(21, 32'h2222_2222, 4'b1100);
      rd(21);
      wr(22, 32'h3333_3333, 4'b1110); idle(1); rd(22);
      idle(3);

      // R9: deselected load ends the burst; continues do nothing
      cur_tag = "R9";
      wr(30, 32'h9999_0030);
      tick(0, 1, 0, '0, 30, '0);
      tick(1, 0, 0, '0, 30, 32'hBADD_0001);
      tick(1, 0, 0, '0, 30, 32'hBADD_0002);
      tick(1, 1, 1, '0, 30, 32'hBADD_0003);
      idle(2);
      rd(30); cont('0); cont('0); cont('0);
      idle(3);

      // R8: strict read/write alternation every cycle
      cur_tag = "R8";
      for (int i = 0; i < 8; i++) begin
         rd(AW'(48 + (i % 3)));
         wr(AW'(48 + ((i + 1) % 3)), pat(100 + i), 4'(i));
      end
      idle(6);

      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R2: actual pending=%0d expected pending=0", expq.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule